// File: doc/BRIEF.md
# Page-Buffered Parallel Flash Programmer

This block is the programming slave of a small on-chip flash. A host drives a shared 8-bit byte together with a two-bit action select and a high/low byte select. On a rising load strobe, the byte is routed into the command latch, one of the two address bytes, or one of the two data bytes. A separate commit strobe copies the staged 16-bit data word into a page buffer, at the word slot named by the low address bits. A falling write strobe then programs the whole buffered page into the flash array, provided the page-program command is active.

While a page programs, a ready output stays low for a fixed number of clock cycles and then returns high. The buffer is then restored to the erased value (all ones). Every strobe is brought into the system clock through a two-flop synchronizer and acted on at its edge. The flash is a register array modelled with a fixed programming delay. A direct read port exposes any flash word so that contents can be inspected.

Top module: `pflash_prog`

## Requirements
- R1: After reset, readyOut is 1 and every flash word reads 0xFFFF on the debug port.
- R2: A rising edge of loadStb stores dataIn according to actSel: 2'b00 stores an address byte, 2'b01 stores a data byte, 2'b10 stores the command byte, and 2'b11 changes no latch. For address and data bytes, hiSel=1 selects the high byte and hiSel=0 the low byte.
- R3: The 16-bit address {addrHigh, addrLow} selects the word inside a page with its low log2(PAGE_WORDS) bits (bits 4:0 by default). It selects the page with the bits above those, so the upper three bits of the low address byte form the low part of the page number.
- R4: A rising edge of commitStb with hiSel=1 writes {data high, data low} into the page buffer slot named by the word bits. With hiSel=0 the commit has no effect.
- R5: A falling edge of writeStbN, while the command latch holds 0x10 and readyOut is 1, programs the buffered page into the page named by the address latches.
- R6: From that start, readyOut is low for exactly PROG_CYCLES consecutive clock cycles (100 by default). The page contents are visible on the debug port once readyOut is high again.
- R7: A falling edge of writeStbN is ignored when the command latch holds any value other than 0x10, such as the no-operation code 0x00. It is also ignored while readyOut is 0. An ignored edge leaves the page buffer unchanged.
- R8: After programming, every page buffer slot is 0xFFFF. Words of a later page that are not committed therefore read 0xFFFF.
- R9: Programming one page leaves the contents of every other page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 8 | Shared command/address/data byte |
| actSel | input | 2 | Action select for the load strobe |
| hiSel | input | 1 | High/low byte select; qualifies commits |
| loadStb | input | 1 | Load strobe, acts on rising edge |
| commitStb | input | 1 | Buffer commit strobe, acts on rising edge |
| writeStbN | input | 1 | Page write strobe, acts on falling edge |
| readyOut | output | 1 | 1 when idle, 0 while a page programs |
| dbgAddr | input | 11 | Flash word address for direct read |
| dbgData | output | 16 | Flash word at dbgAddr |

## Verification
The assertions take dataIn, actSel and hiSel to be stable for the synchronizer delay around every strobe edge. This matters because those levels are sampled unsynchronized when the edge is detected. The commit check in particular relies on hiSel being constant for the whole width of a commit pulse. The bench sets the level inputs one cycle before raising a strobe and holds them for several cycles after releasing it. It also keeps each strobe level for three cycles, so every edge passes the synchronizer exactly once.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

  typedef struct packed {
    logic loadAddrLo;
    logic loadAddrHi;
    logic loadDataLo;
    logic loadDataHi;
    logic loadCmd;
    logic commitWord;
    logic startProg;
    logic finishProg;
  } pfpStrobes_t;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'b00,
    SEL_DATA = 2'b01,
    SEL_CMD  = 2'b10,
    SEL_NONE = 2'b11
  } pfpSel_e;

  localparam logic [7:0] CMD_PAGE_PROG = 8'h10;

endpackage

// File: rtl/pfp_sync_edge.sv
// Two-flop synchronizer plus edge detector for each strobe.
module pfp_sync_edge #(
  parameter int N = 3,
  parameter logic [N-1:0] ACT_LOW = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] strobeIn,
  output logic [N-1:0] edgeOut
);

  for (genvar g = 0; g < N; g++) begin : g_strobe
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1 <= ACT_LOW[g];
        s2 <= ACT_LOW[g];
        s3 <= ACT_LOW[g];
      end else begin
        s1 <= strobeIn[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    // an active-low strobe acts on its fall, an active-high one on its rise
    if (ACT_LOW[g]) begin : g_fall
      assign edgeOut[g] = s3 & ~s2;
    end else begin : g_rise
      assign edgeOut[g] = s2 & ~s3;
    end
  end

endmodule

// File: rtl/pfp_ctrl.sv
// Decodes strobe edges into datapath actions; owns the command latch and the busy timer.
module pfp_ctrl
  import pfp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        selIn,
  input  logic              hiSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              loadEdge,
  input  logic              commitEdge,
  input  logic              writeEdge,
  output pfpStrobes_t       strobes,
  output logic              busy
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [DATA_W-1:0] cmdReg;
  logic [CNT_W-1:0]  cnt;
  logic              progArmed;

  assign progArmed = (cmdReg == DATA_W'(CMD_PAGE_PROG));

  always_comb begin
    strobes = '0;
    if (loadEdge) begin
      unique case (pfpSel_e'(selIn))
        SEL_ADDR: begin
          strobes.loadAddrHi = hiSel;
          strobes.loadAddrLo = ~hiSel;
        end
        SEL_DATA: begin
          strobes.loadDataHi = hiSel;
          strobes.loadDataLo = ~hiSel;
        end
        SEL_CMD:  strobes.loadCmd = 1'b1;
        SEL_NONE: ;
        default:  ;
      endcase
    end
    strobes.commitWord = commitEdge & hiSel;
    strobes.startProg  = writeEdge & ~busy & progArmed;
    strobes.finishProg = busy & (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (strobes.loadCmd) begin
      cmdReg <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (strobes.startProg) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(PROG_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pfp_datapath.sv
// Address/data latches, page buffer and flash array model.
module pfp_datapath
  import pfp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_WORDS = 32,
  parameter int NUM_PAGES  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  pfpStrobes_t       strobes,
  input  logic [$clog2(PAGE_WORDS)+$clog2(NUM_PAGES)-1:0] dbgAddr,
  output logic [2*DATA_W-1:0] dbgData
);

  localparam int WORD_W    = 2 * DATA_W;
  localparam int WORD_BITS = $clog2(PAGE_WORDS);
  localparam int PAGE_BITS = $clog2(NUM_PAGES);
  localparam int ADDR_BITS = WORD_BITS + PAGE_BITS;
  localparam int HI_BITS   = ADDR_BITS - DATA_W;
  localparam logic [WORD_W-1:0] ERASED = '1;

  logic [DATA_W-1:0]    addrLo;
  logic [HI_BITS-1:0]   addrHi;
  logic [DATA_W-1:0]    dataLo;
  logic [DATA_W-1:0]    dataHi;
  logic [ADDR_BITS-1:0] fullAddr;
  logic [WORD_BITS-1:0] wordIdx;
  logic [PAGE_BITS-1:0] pageIdx;
  logic [PAGE_BITS-1:0] progPage;
  logic [WORD_W-1:0]    pageBuf  [PAGE_WORDS];
  logic [WORD_W-1:0]    flashMem [NUM_PAGES][PAGE_WORDS];

  assign fullAddr = {addrHi, addrLo};
  assign wordIdx  = fullAddr[WORD_BITS-1:0];
  assign pageIdx  = fullAddr[ADDR_BITS-1:WORD_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo <= '0;
      addrHi <= '0;
      dataLo <= '1;
      dataHi <= '1;
    end else begin
      if (strobes.loadAddrLo) addrLo <= dataIn;
      if (strobes.loadAddrHi) addrHi <= dataIn[HI_BITS-1:0];
      if (strobes.loadDataLo) dataLo <= dataIn;
      if (strobes.loadDataHi) dataHi <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < PAGE_WORDS; w++) pageBuf[w] <= ERASED;
    end else if (strobes.finishProg) begin
      for (int w = 0; w < PAGE_WORDS; w++) pageBuf[w] <= ERASED;
    end else if (strobes.commitWord) begin
      pageBuf[wordIdx] <= {dataHi, dataLo};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progPage <= '0;
    end else if (strobes.startProg) begin
      progPage <= pageIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int w = 0; w < PAGE_WORDS; w++)
          flashMem[p][w] <= ERASED;
    end else if (strobes.finishProg) begin
      for (int w = 0; w < PAGE_WORDS; w++)
        flashMem[progPage][w] <= pageBuf[w];
    end
  end

  assign dbgData = flashMem[dbgAddr[ADDR_BITS-1:WORD_BITS]][dbgAddr[WORD_BITS-1:0]];

endmodule

// File: rtl/pflash_prog.sv
module pflash_prog
  import pfp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PAGE_WORDS  = 32,
  parameter int NUM_PAGES   = 64,
  parameter int PROG_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [1:0]        actSel,
  input  logic              hiSel,
  input  logic              loadStb,
  input  logic              commitStb,
  input  logic              writeStbN,
  output logic              readyOut,
  input  logic [$clog2(PAGE_WORDS)+$clog2(NUM_PAGES)-1:0] dbgAddr,
  output logic [2*DATA_W-1:0] dbgData
);

  logic [2:0]  strobeEdge;
  logic        busy;
  pfpStrobes_t ctrlStrobes;

  pfp_sync_edge #(.N(3), .ACT_LOW(3'b100)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobeIn({writeStbN, commitStb, loadStb}),
    .edgeOut (strobeEdge)
  );

  pfp_ctrl #(.DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .selIn     (actSel),
    .hiSel     (hiSel),
    .dataIn    (dataIn),
    .loadEdge  (strobeEdge[0]),
    .commitEdge(strobeEdge[1]),
    .writeEdge (strobeEdge[2]),
    .strobes   (ctrlStrobes),
    .busy      (busy)
  );

  pfp_datapath #(.DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .dataIn (dataIn),
    .strobes(ctrlStrobes),
    .dbgAddr(dbgAddr),
    .dbgData(dbgData)
  );

  assign readyOut = ~busy;

endmodule

// File: rtl/pfp_checker.sv
module pfp_checker
  import pfp_pkg::*;
#(
  parameter int PROG_CYCLES = 100
) (
  input logic        clk,
  input logic        rstN,
  input logic        hiSel,
  input logic        readyOut,
  input pfpStrobes_t strobes
);

  localparam int LC_W = $clog2(PROG_CYCLES + 2);

  // counts consecutive cycles with readyOut low, saturating
  logic [LC_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (readyOut) lowCnt <= '0;
    else if (lowCnt != LC_W'(PROG_CYCLES + 1)) lowCnt <= lowCnt + 1'b1;
  end

  p_single_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadAddrLo, strobes.loadAddrHi, strobes.loadDataLo,
              strobes.loadDataHi, strobes.loadCmd}));

  p_commit_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitWord |-> hiSel);

  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startProg |-> readyOut);

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startProg |=> !readyOut);

  p_finish_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finishProg |=> readyOut);

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyOut) |-> (lowCnt == LC_W'(PROG_CYCLES)));

  p_low_bounded_r6: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |-> (lowCnt < LC_W'(PROG_CYCLES)));

endmodule

bind pflash_prog pfp_checker #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .hiSel   (hiSel),
  .readyOut(readyOut),
  .strobes (ctrlStrobes)
);

// File: tb/pflash_prog_tb_top.sv
module pflash_prog_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC   = 100;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  dataIn;
  logic [1:0]  actSel;
  logic        hiSel;
  logic        loadStb;
  logic        commitStb;
  logic        writeStbN;
  logic        readyOut;
  logic [10:0] dbgAddr;
  logic [15:0] dbgData;

  int testsRun  = 0;
  int testsFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pflash_prog dut_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .actSel(actSel), .hiSel(hiSel),
    .loadStb(loadStb), .commitStb(commitStb), .writeStbN(writeStbN),
    .readyOut(readyOut), .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  function automatic logic [15:0] expVal(int page, int w);
    return {8'(page) ^ 8'hA5, 8'(w) ^ 8'h3C};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic loadByte(logic [1:0] sel, logic hi, logic [7:0] b);
    @(negedge clk);
    actSel = sel; hiSel = hi; dataIn = b;
    @(negedge clk); loadStb = 1'b1;
    repeat (3) @(negedge clk);
    loadStb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic commitPulse(logic hi);
    @(negedge clk); hiSel = hi;
    @(negedge clk); commitStb = 1'b1;
    repeat (3) @(negedge clk);
    commitStb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // word address = page*32 + w; low byte carries page bits above bit 4
  task automatic stageWord(int page, int w, logic [15:0] val, logic hiCommit);
    int full = page * 32 + w;
    loadByte(2'b00, 1'b0, 8'(full));
    loadByte(2'b01, 1'b0, val[7:0]);
    loadByte(2'b01, 1'b1, val[15:8]);
    commitPulse(hiCommit);
  endtask

  task automatic setPageHigh(int page);
    int full = page * 32;
    loadByte(2'b00, 1'b1, 8'(full >> 8));
  endtask

  task automatic writePage(bit extraWr, output int lowCycles);
    bit seen = 1'b0;
    lowCycles = 0;
    @(negedge clk); writeStbN = 1'b0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (i == 3) writeStbN = 1'b1;
      if (extraWr && i == 40) writeStbN = 1'b0;
      if (extraWr && i == 43) writeStbN = 1'b1;
      if (!readyOut) begin
        lowCycles++;
        seen = 1'b1;
      end else if (seen) begin
        break;
      end
      if (!seen && i >= 200) break;
    end
    writeStbN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic readWord(int page, int w, output logic [15:0] v);
    @(negedge clk);
    dbgAddr = 11'(page * 32 + w);
    #1 v = dbgData;
  endtask

  task automatic test_reset();
    logic [15:0] v;
    check(readyOut === 1'b1, "R1 ready after reset", int'(readyOut), 1);
    readWord(0, 0, v);
    check(v === 16'hFFFF, "R1 erased word 0", int'(v), 16'hFFFF);
    readWord(63, 31, v);
    check(v === 16'hFFFF, "R1 erased last word", int'(v), 16'hFFFF);
  endtask

  task automatic test_full_page();
    logic [15:0] v;
    int lc, bad;
    loadByte(2'b10, 1'b0, 8'h10);
    for (int w = 0; w < 32; w++) stageWord(9, w, expVal(9, w), 1'b1);
    setPageHigh(9);
    writePage(1'b0, lc);
    check(lc == PROG_CYC, "R6 busy length", lc, PROG_CYC);
    bad = 0;
    for (int w = 0; w < 32; w++) begin
      readWord(9, w, v);
      if (v !== expVal(9, w)) bad++;
    end
    check(bad == 0, "R5 R2 R4 full page contents", bad, 0);
    readWord(9, 17, v);
    check(v === expVal(9, 17), "R3 word 17 of page 9", int'(v), int'(expVal(9, 17)));
    readWord(8, 17, v);
    check(v === 16'hFFFF, "R3 neighbour page 8 untouched", int'(v), 16'hFFFF);
    readWord(10, 0, v);
    check(v === 16'hFFFF, "R3 neighbour page 10 untouched", int'(v), 16'hFFFF);
  endtask

  task automatic test_partial_page();
    logic [15:0] v;
    int lc, bad;
    for (int w = 0; w < 32; w += 2) stageWord(3, w, expVal(3, w), 1'b1);
    setPageHigh(3);
    writePage(1'b0, lc);
    check(lc == PROG_CYC, "R6 busy length page 3", lc, PROG_CYC);
    bad = 0;
    for (int w = 0; w < 32; w++) begin
      readWord(3, w, v);
      if ((w % 2 == 0) ? (v !== expVal(3, w)) : (v !== 16'hFFFF)) bad++;
    end
    check(bad == 0, "R8 buffer reset between pages", bad, 0);
    readWord(9, 5, v);
    check(v === expVal(9, 5), "R9 page 9 preserved", int'(v), int'(expVal(9, 5)));
  endtask

  task automatic test_low_commit();
    logic [15:0] v;
    int lc;
    stageWord(40, 2, expVal(40, 2), 1'b1);
    stageWord(40, 7, expVal(40, 7), 1'b0);
    setPageHigh(40);
    writePage(1'b0, lc);
    readWord(40, 7, v);
    check(v === 16'hFFFF, "R4 commit with low select ignored", int'(v), 16'hFFFF);
    readWord(40, 2, v);
    check(v === expVal(40, 2), "R4 commit with high select", int'(v), int'(expVal(40, 2)));
  endtask

  task automatic test_idle_select();
    logic [15:0] v;
    int lc;
    int full = 50 * 32 + 4;
    loadByte(2'b00, 1'b0, 8'(full));
    loadByte(2'b01, 1'b0, 8'h12);
    loadByte(2'b01, 1'b1, 8'h34);
    loadByte(2'b11, 1'b0, 8'h55);
    loadByte(2'b11, 1'b1, 8'hAA);
    commitPulse(1'b1);
    setPageHigh(50);
    writePage(1'b0, lc);
    check(lc == PROG_CYC, "R2 command kept through select 11", lc, PROG_CYC);
    readWord(50, 4, v);
    check(v === 16'h3412, "R2 select 11 changes no latch", int'(v), 16'h3412);
    readWord(50, 21, v);
    check(v === 16'hFFFF, "R2 select 11 not an address", int'(v), 16'hFFFF);
  endtask

  task automatic test_nop();
    logic [15:0] v;
    int lc;
    loadByte(2'b10, 1'b0, 8'h00);
    stageWord(20, 1, expVal(20, 1), 1'b1);
    setPageHigh(20);
    writePage(1'b0, lc);
    check(lc == 0, "R7 write ignored after no-op", lc, 0);
    readWord(20, 1, v);
    check(v === 16'hFFFF, "R7 page unchanged after no-op", int'(v), 16'hFFFF);
    loadByte(2'b10, 1'b0, 8'h3C);
    writePage(1'b0, lc);
    check(lc == 0, "R7 write ignored for other code", lc, 0);
    loadByte(2'b10, 1'b0, 8'h10);
    writePage(1'b0, lc);
    check(lc == PROG_CYC, "R7 program after re-arm", lc, PROG_CYC);
    readWord(20, 1, v);
    check(v === expVal(20, 1), "R7 buffer kept across ignored writes", int'(v), int'(expVal(20, 1)));
  endtask

  task automatic test_busy_write();
    logic [15:0] v;
    int lc;
    stageWord(60, 0, expVal(60, 0), 1'b1);
    setPageHigh(60);
    writePage(1'b1, lc);
    check(lc == PROG_CYC, "R7 write while busy ignored", lc, PROG_CYC);
    readWord(60, 0, v);
    check(v === expVal(60, 0), "R5 page 60 programmed", int'(v), int'(expVal(60, 0)));
    readWord(3, 4, v);
    check(v === expVal(3, 4), "R9 page 3 preserved", int'(v), int'(expVal(3, 4)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsFail++;
    testsRun++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; dataIn = '0; actSel = '0; hiSel = 1'b0;
    loadStb = 1'b0; commitStb = 1'b0; writeStbN = 1'b1; dbgAddr = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_full_page();
    test_partial_page();
    test_low_commit();
    test_idle_select();
    test_nop();
    test_busy_write();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule